// File: doc/BRIEF.md
# Terminal Character I/O and Interrupt Unit

This unit sits between an accumulator machine's control sequencer and a character terminal. It holds one received character with its "input full" flag and one outgoing character with its "output free" flag. It also holds the interrupt-enable bit and the interrupt-pending bit. The device side is a parallel byte interface. The device strobes in a new character. The unit shows an outgoing byte with a valid level, and the device answers with an acknowledge once it has taken that byte. Serial shifting belongs to the terminal interface and is not part of this unit.

On the CPU side, the sequencer raises `io_exec` during the execute step of an I/O-class instruction and presents instruction bits 11 down to 6. Each of these bits selects one action: take the input byte, send the output byte, skip on input flag, skip on output flag, enable interrupts, or disable interrupts. The unit returns a skip request, the received byte with a load strobe for the accumulator's low byte, a sequence-counter clear, and the pending-interrupt bit. While the pending bit is set, the three fetch timing pulses are converted into three interrupt-cycle step strobes. The datapath uses these strobes to save the return address at address 0 and to resume at address 1.

Top module: `term_io_irq`

## Requirements
- R1: After reset, the input flag is 0 and the output flag is 1. Interrupt enable and interrupt pending are 0, `out_valid` is 0, and both character registers are 0.
- R2: A cycle with `dev_in_stb` high loads `dev_in_data` into the input register and sets the input flag, with effect from the next cycle. `in_byte` always shows the input register. With `io_exec` high and bit 11 set, `in_load` is high in that cycle, and the input flag clears on the next edge.
- R3: With `io_exec` high and bit 10 set, `ac_low` is loaded into the output register and the output flag clears on the next edge. `out_data` changes at no other time. `out_valid` is the inverse of the output flag.
- R4: A cycle with `dev_out_ack` high sets the output flag from the next cycle.
- R5: `skip_req` is high in a cycle where `io_exec` is high and either bit 9 is set with the input flag at 1, or bit 8 is set with the output flag at 1.
- R6: With `io_exec` high, bit 7 sets interrupt enable and bit 6 clears it. When both bits are set, the clear wins.
- R7: Interrupt pending sets on the next edge only in a cycle where all three `fetch_t` pulses are low, interrupt enable is 1 and at least one flag is 1. It never sets in a cycle with a fetch pulse high.
- R8: `icyc[k]` equals interrupt pending AND `fetch_t[k]` for k = 0, 1, 2. After a cycle with `icyc[2]` high, both interrupt pending and interrupt enable are 0.
- R9: `sc_clr` is high in a cycle where `io_exec` is high or `icyc[2]` is high.
- R10: When a device strobe or acknowledge coincides with an instruction that clears the same flag, the flag ends set. For the input side, the new character is kept.
- R11: With `io_exec` low, bits 11 to 6 change no flag, register or enable bit, and `skip_req` and `in_load` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_in_stb | input | 1 | Device delivers a new character |
| dev_in_data | input | 8 | Character from the device |
| dev_out_ack | input | 1 | Device has consumed the output byte |
| out_data | output | 8 | Output character register |
| out_valid | output | 1 | Output byte waiting for the device |
| io_exec | input | 1 | I/O instruction execute step |
| io_bits | input | 6 | Instruction bits 11 down to 6 |
| ac_low | input | 8 | Accumulator low byte |
| fetch_t | input | 3 | Fetch timing pulses T0, T1, T2 |
| in_byte | output | 8 | Input character register for the accumulator |
| in_load | output | 1 | Load accumulator low byte from `in_byte` |
| skip_req | output | 1 | Skip the next instruction |
| sc_clr | output | 1 | Clear the sequence counter |
| in_flag | output | 1 | Input-full flag |
| out_flag | output | 1 | Output-free flag |
| int_en | output | 1 | Interrupt enable |
| irq_pend | output | 1 | Interrupt pending |
| icyc | output | 3 | Interrupt-cycle step strobes |

## Verification
Two cases are hard to reach from the ports: a device event landing in the same cycle as the instruction that clears the same flag, and the raising of the pending bit right next to fetch pulses. Directed sequences place a strobe on the same edge as the take-input command, and an acknowledge on the same edge as the send command. A three-step interrupt cycle is also driven while a flag stays set, so the pending bit must not re-arm during that cycle. A long pseudo-random phase then mixes one-hot fetch pulses, idle gaps and all six command bits. Every output is compared against a behavioural model on every cycle.

// File: rtl/tio_pkg.sv
package tio_pkg;
  parameter int unsigned CHAR_W = 8;
  parameter int unsigned ISTEPS = 3;

  localparam int unsigned B_INP = 11;
  localparam int unsigned B_OUT = 10;
  localparam int unsigned B_SKI = 9;
  localparam int unsigned B_SKO = 8;
  localparam int unsigned B_ION = 7;
  localparam int unsigned B_IOF = 6;

  typedef struct packed {
    logic take_in;
    logic send_out;
    logic skip_in;
    logic skip_out;
    logic irq_on;
    logic irq_off;
  } io_cmd_t;
endpackage

// File: rtl/tio_decode.sv
module tio_decode
  import tio_pkg::*;
(
  input  logic        io_exec,
  input  logic [11:6] io_bits,
  output io_cmd_t     cmd
);
  always_comb begin
    cmd.take_in  = io_exec & io_bits[B_INP];
    cmd.send_out = io_exec & io_bits[B_OUT];
    cmd.skip_in  = io_exec & io_bits[B_SKI];
    cmd.skip_out = io_exec & io_bits[B_SKO];
    cmd.irq_on   = io_exec & io_bits[B_ION];
    cmd.irq_off  = io_exec & io_bits[B_IOF];
  end
endmodule

// File: rtl/tio_chan.sv
module tio_chan #(
  parameter int unsigned W        = 8,
  parameter bit          RST_FLAG = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  input  logic         flag_set,
  input  logic         flag_clr,
  output logic [W-1:0] data_q,
  output logic         flag_q
);
  logic [W-1:0] data_d;
  logic         flag_d;

  always_comb begin
    data_d = data_q;
    if (ld_en) data_d = ld_data;
    flag_d = flag_q;
    if (flag_set)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= RST_FLAG;
    end else begin
      if (ld_en) data_q <= data_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/tio_irq_ctl.sv
module tio_irq_ctl #(
  parameter int unsigned NSTEP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_on,
  input  logic             irq_off,
  input  logic [NSTEP-1:0] fetch_t,
  input  logic             fgi,
  input  logic             fgo,
  output logic             ien_q,
  output logic             r_q,
  output logic [NSTEP-1:0] step
);
  localparam int unsigned LAST = NSTEP - 1;
  logic ien_d, r_d, leave;

  for (genvar k = 0; k < NSTEP; k++) begin : g_step
    assign step[k] = r_q & fetch_t[k];
  end

  assign leave = step[LAST];

  always_comb begin
    ien_d = ien_q;
    if (leave || irq_off) ien_d = 1'b0;
    else if (irq_on)      ien_d = 1'b1;
    r_d = r_q;
    if (leave) r_d = 1'b0;
    else if ((fetch_t == '0) && ien_q && (fgi || fgo)) r_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      r_q   <= 1'b0;
    end else begin
      ien_q <= ien_d;
      r_q   <= r_d;
    end
  end
endmodule

// File: rtl/term_io_irq.sv
module term_io_irq
  import tio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_in_stb,
  input  logic [CHAR_W-1:0] dev_in_data,
  input  logic              dev_out_ack,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_valid,
  input  logic              io_exec,
  input  logic [11:6]       io_bits,
  input  logic [CHAR_W-1:0] ac_low,
  input  logic [ISTEPS-1:0] fetch_t,
  output logic [CHAR_W-1:0] in_byte,
  output logic              in_load,
  output logic              skip_req,
  output logic              sc_clr,
  output logic              in_flag,
  output logic              out_flag,
  output logic              int_en,
  output logic              irq_pend,
  output logic [ISTEPS-1:0] icyc
);
  logic [1:0] rst_sync;
  logic       rst_int_n;
  io_cmd_t    cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  tio_decode u_dec (
    .io_exec (io_exec),
    .io_bits (io_bits),
    .cmd     (cmd)
  );

  tio_chan #(.W(CHAR_W), .RST_FLAG(1'b0)) u_in (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ld_en    (dev_in_stb),
    .ld_data  (dev_in_data),
    .flag_set (dev_in_stb),
    .flag_clr (cmd.take_in),
    .data_q   (in_byte),
    .flag_q   (in_flag)
  );

  tio_chan #(.W(CHAR_W), .RST_FLAG(1'b1)) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ld_en    (cmd.send_out),
    .ld_data  (ac_low),
    .flag_set (dev_out_ack),
    .flag_clr (cmd.send_out),
    .data_q   (out_data),
    .flag_q   (out_flag)
  );

  tio_irq_ctl #(.NSTEP(ISTEPS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .irq_on  (cmd.irq_on),
    .irq_off (cmd.irq_off),
    .fetch_t (fetch_t),
    .fgi     (in_flag),
    .fgo     (out_flag),
    .ien_q   (int_en),
    .r_q     (irq_pend),
    .step    (icyc)
  );

  assign out_valid = ~out_flag;
  assign in_load   = cmd.take_in;
  assign skip_req  = (cmd.skip_in & in_flag) | (cmd.skip_out & out_flag);
  assign sc_clr    = io_exec | icyc[ISTEPS-1];
endmodule

// File: rtl/tio_checker.sv
module tio_checker #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 3
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         dev_in_stb,
  input logic         dev_out_ack,
  input logic         io_exec,
  input logic [11:6]  io_bits,
  input logic [N-1:0] fetch_t,
  input logic         in_flag,
  input logic         out_flag,
  input logic         int_en,
  input logic         irq_pend,
  input logic         skip_req,
  input logic [W-1:0] out_data,
  input logic [N-1:0] icyc
);
  AST_IN_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_ok)
    dev_in_stb |=> in_flag); // R10
  AST_OUT_ACK_SETS: assert property (@(posedge clk) disable iff (!rst_ok)
    dev_out_ack |=> out_flag); // R4
  AST_OUT_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !(io_exec && io_bits[10]) |=> $stable(out_data)); // R3
  AST_ICYC_EXIT: assert property (@(posedge clk) disable iff (!rst_ok)
    icyc[N-1] |=> (!irq_pend && !int_en)); // R8
  AST_NO_PEND_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_ok)
    (!irq_pend && (fetch_t != '0)) |=> !irq_pend); // R7
  AST_SKIP_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    !io_exec |-> !skip_req); // R11
  AST_ICYC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0(fetch_t) |-> $onehot0(icyc)); // R8
endmodule

bind term_io_irq tio_checker #(.W(tio_pkg::CHAR_W), .N(tio_pkg::ISTEPS)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_int_n),
  .dev_in_stb  (dev_in_stb),
  .dev_out_ack (dev_out_ack),
  .io_exec     (io_exec),
  .io_bits     (io_bits),
  .fetch_t     (fetch_t),
  .in_flag     (in_flag),
  .out_flag    (out_flag),
  .int_en      (int_en),
  .irq_pend    (irq_pend),
  .skip_req    (skip_req),
  .out_data    (out_data),
  .icyc        (icyc)
);

// File: tb/tb_term_io_irq.sv
`timescale 1ns/1ps
module tb_term_io_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dev_in_stb = 1'b0;
  logic [7:0] dev_in_data = '0;
  logic       dev_out_ack = 1'b0;
  logic       io_exec = 1'b0;
  logic [11:6] io_bits = '0;
  logic [7:0] ac_low = '0;
  logic [2:0] fetch_t = '0;
  logic [7:0] out_data, in_byte;
  logic       out_valid, in_load, skip_req, sc_clr, in_flag, out_flag, int_en, irq_pend;
  logic [2:0] icyc;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state
  logic [7:0] m_in, m_out;
  logic       m_fgi, m_fgo, m_ien, m_r;

  always #2.5 clk = ~clk;

  term_io_irq dut (
    .clk(clk), .rst_n(rst_n), .dev_in_stb(dev_in_stb), .dev_in_data(dev_in_data),
    .dev_out_ack(dev_out_ack), .out_data(out_data), .out_valid(out_valid),
    .io_exec(io_exec), .io_bits(io_bits), .ac_low(ac_low), .fetch_t(fetch_t),
    .in_byte(in_byte), .in_load(in_load), .skip_req(skip_req), .sc_clr(sc_clr),
    .in_flag(in_flag), .out_flag(out_flag), .int_en(int_en), .irq_pend(irq_pend),
    .icyc(icyc)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic sk;
    sk = io_exec & ((io_bits[9] & m_fgi) | (io_bits[8] & m_fgo));
    chk("R2", "in_byte", in_byte, m_in);
    chk("R2", "in_flag", {7'b0, in_flag}, {7'b0, m_fgi});
    chk("R2", "in_load", {7'b0, in_load}, {7'b0, io_exec & io_bits[11]});
    chk("R3", "out_data", out_data, m_out);
    chk("R3", "out_valid", {7'b0, out_valid}, {7'b0, ~m_fgo});
    chk("R4", "out_flag", {7'b0, out_flag}, {7'b0, m_fgo});
    chk("R5", "skip_req", {7'b0, skip_req}, {7'b0, sk});
    chk("R6", "int_en", {7'b0, int_en}, {7'b0, m_ien});
    chk("R7", "irq_pend", {7'b0, irq_pend}, {7'b0, m_r});
    chk("R8", "icyc", {5'b0, icyc}, {5'b0, {3{m_r}} & fetch_t});
    chk("R9", "sc_clr", {7'b0, sc_clr}, {7'b0, io_exec | (m_r & fetch_t[2])});
  endtask

  task automatic model_edge();
    logic leave, n_fgi, n_fgo, n_ien, n_r;
    leave = m_r & fetch_t[2];
    n_fgi = dev_in_stb ? 1'b1 : ((io_exec && io_bits[11]) ? 1'b0 : m_fgi);
    n_fgo = dev_out_ack ? 1'b1 : ((io_exec && io_bits[10]) ? 1'b0 : m_fgo);
    if (leave || (io_exec && io_bits[6])) n_ien = 1'b0;
    else if (io_exec && io_bits[7])       n_ien = 1'b1;
    else                                  n_ien = m_ien;
    if (leave) n_r = 1'b0;
    else if (fetch_t == 3'b000 && m_ien && (m_fgi || m_fgo)) n_r = 1'b1;
    else n_r = m_r;
    if (dev_in_stb) m_in = dev_in_data;
    if (io_exec && io_bits[10]) m_out = ac_low;
    m_fgi = n_fgi; m_fgo = n_fgo; m_ien = n_ien; m_r = n_r;
  endtask

  // inputs already driven at negedge; compare, then clock, then update model
  task automatic step();
    #1 compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    dev_in_stb = 0; dev_out_ack = 0; io_exec = 0; io_bits = '0; fetch_t = '0;
  endtask

  task automatic io(input logic [11:6] b);
    idle(); io_exec = 1; io_bits = b; step();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    m_in = 0; m_out = 0; m_fgi = 0; m_fgo = 1; m_ien = 0; m_r = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "in_flag", {7'b0, in_flag}, 8'h00);
    chk("R1", "out_flag", {7'b0, out_flag}, 8'h01);
    chk("R1", "out_valid", {7'b0, out_valid}, 8'h00);
    chk("R1", "int_en/irq_pend", {6'b0, int_en, irq_pend}, 8'h00);
    chk("R1", "regs", in_byte | out_data, 8'h00);

    // R2: character arrives, then taken
    idle(); dev_in_stb = 1; dev_in_data = 8'h5A; step();
    idle(); step();
    io(6'b001000);          // R5 skip on input flag
    io(6'b100000);          // take input
    idle(); step();
    chk("R2", "flag cleared after take", {7'b0, in_flag}, 8'h00);

    // R3: send a byte; R4 device acknowledges
    ac_low = 8'hC3; io(6'b010000);
    idle(); step();
    chk("R3", "out_valid while busy", {7'b0, out_valid}, 8'h01);
    io(6'b000100);          // R5 skip on output flag, flag is 0 here
    idle(); dev_out_ack = 1; step();
    idle(); step();

    // R10: device strobe collides with take, ack collides with send
    io(6'b000000);
    idle(); dev_in_stb = 1; dev_in_data = 8'h11; step();
    idle(); dev_in_stb = 1; dev_in_data = 8'h22; io_exec = 1; io_bits = 6'b100000; step();
    chk("R10", "input flag kept", {7'b0, in_flag}, 8'h01);
    chk("R10", "new char kept", in_byte, 8'h22);
    idle(); ac_low = 8'h77; dev_out_ack = 1; io_exec = 1; io_bits = 6'b010000; step();
    chk("R10", "output flag kept", {7'b0, out_flag}, 8'h01);

    // R11: bits without io_exec have no effect
    idle(); io_bits = 6'b111111; ac_low = 8'h99; step();
    idle(); step();
    chk("R11", "out_data unchanged", out_data, 8'h77);
    chk("R11", "flags/enable unchanged", {5'b0, in_flag, out_flag, int_en}, 8'h06);

    // R6: enable, both-bits precedence
    io(6'b000011);
    chk("R6", "both bits clear", {7'b0, int_en}, 8'h00);
    io(6'b000010);
    // R7: pend held off during fetch pulses, set in gap
    idle(); fetch_t = 3'b001; step();
    idle(); fetch_t = 3'b010; step();
    chk("R7", "no pend during fetch", {7'b0, irq_pend}, 8'h00);
    idle(); step();
    chk("R7", "pend after gap", {7'b0, irq_pend}, 8'h01);
    // R8: interrupt cycle with flags still set
    idle(); fetch_t = 3'b001; step();
    idle(); fetch_t = 3'b010; step();
    idle(); fetch_t = 3'b100; step();
    chk("R8", "exit clears pend/enable", {6'b0, irq_pend, int_en}, 8'h00);
    idle(); step();

    // mixed pseudo-random traffic
    for (int i = 0; i < 4000; i++) begin
      int ph;
      idle();
      ph = i % 6;
      dev_in_stb  = ($urandom % 5) == 0;
      dev_in_data = 8'($urandom);
      dev_out_ack = ($urandom % 5) == 0;
      ac_low      = 8'($urandom);
      if (ph < 3) fetch_t = 3'(1 << ph);
      else if (ph == 3 && ($urandom % 2) == 0) fetch_t = 3'b000;
      io_exec = (ph == 4) && ($urandom % 3 != 0);
      io_bits = 6'($urandom);
      if (($urandom % 4) == 0) io_bits = io_bits & 6'b000010;
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule